// File: doc/BRIEF.md
# Packet page allocator

This block keeps the books for an on-chip packet buffer that a simple Ethernet MAC carves into fixed 256-byte pages. It does not hold packet data. A host issues one command per cycle on a small command port. Each command is an allocate, a reset of the allocator, an enqueue for transmit, a free of a transmitted packet, or a release of the oldest received packet.

An allocation returns a packet number and the first page of the packet's run. The allocator tracks which pages are in use with a bitmap. It remembers each packet number's run of pages in a small table. It keeps a transmit queue and a receive queue of packet numbers.

The host sizes each request from the frame length. It clears bit 0 of the byte count, adds 6 and shifts right by 8. The result goes into the command's argument field, and the allocator grants that value plus one page. The block reports the free space in 2048-byte units. It also reports a busy flag, an allocation-done interrupt bit, a failure flag and a sticky error bit for commands that arrive while busy.

Top module: `pkt_page_alloc`

## Requirements
- R1: After the synchronous active-low reset, every page is free, no packet number is in use, both queues are empty, and busy, cmd_err, alloc_int and alloc_fail are all 0.
- R2: An allocate command (cmd_op = 1) whose argument holds v requests v+1 consecutive pages, so v = 0 still takes one page.
- R3: A successful allocation returns the lowest unused packet number on alloc_pkt. It takes the lowest-addressed run of free pages that fits, and puts the first page of that run on alloc_base. Both outputs are valid in the cycle after the command.
- R4: A successful allocation sets alloc_int in the next cycle. A 1 on int_ack clears it. If an allocation succeeds in the same cycle as int_ack, alloc_int stays set.
- R5: If no fitting run of pages or no packet number is left, alloc_fail goes to 1 in the next cycle and alloc_int is not set by that command. No page or packet number is taken. The next successful allocation clears alloc_fail.
- R6: free_units equals the number of free pages divided by 8, rounded down. This counts 2048-byte units.
- R7: An enqueue command (cmd_op = 3) appends the packet number in its argument to the transmit queue. tx_head shows the oldest entry while tx_empty is 0. A tx_pop pulse removes that entry.
- R8: A free command (cmd_op = 4) returns every page of the packet number in its argument and makes that number available again. Freeing a number that is not in use changes nothing.
- R9: rx_push appends rx_push_pkt to the receive queue. rx_head shows the oldest entry and rx_empty is 1 when the queue is empty. A release command (cmd_op = 5) removes that entry and returns its pages. A release with an empty queue changes nothing.
- R10: Free, release and reset (cmd_op = 4, 5, 2) raise busy for exactly 4 cycles, starting with the cycle after the command. Allocate and enqueue never raise busy.
- R11: Any command presented while busy is 1 is ignored and sets cmd_err. cmd_err then stays 1 until a reset command or rst_n.
- R12: A reset command (cmd_op = 2) makes all pages free and all packet numbers unused. It empties both queues and clears alloc_int, alloc_fail and cmd_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code: 1 allocate, 2 reset, 3 enqueue, 4 free, 5 release |
| cmd_arg | input | max(log2 NUM_PAGES, log2 NUM_PKTS) | Page count minus one (allocate) or packet number (enqueue, free) |
| int_ack | input | 1 | Write-one-to-clear for alloc_int |
| rx_push | input | 1 | Receive engine appends a packet number |
| rx_push_pkt | input | log2 NUM_PKTS | Packet number being appended |
| tx_pop | input | 1 | Transmit engine takes the transmit queue head |
| busy | output | 1 | A free, release or reset command is in progress |
| cmd_err | output | 1 | Sticky: a command arrived while busy |
| alloc_int | output | 1 | Allocation-done interrupt bit |
| alloc_fail | output | 1 | Last allocation could not be served |
| alloc_pkt | output | log2 NUM_PKTS | Packet number granted by the last successful allocation |
| alloc_base | output | log2 NUM_PAGES | First page of that packet's run |
| free_units | output | log2(NUM_PAGES/8+1) | Free memory in 2048-byte units |
| tx_empty | output | 1 | Transmit queue is empty |
| tx_head | output | log2 NUM_PKTS | Oldest packet number in the transmit queue |
| rx_empty | output | 1 | Receive queue is empty |
| rx_head | output | log2 NUM_PKTS | Oldest packet number in the receive queue |

## Verification
The bench builds the allocator with 16 pages and 8 packet numbers, keeping 8 pages per unit and a 4-cycle busy window. At this size every pair of back-to-back request sizes can be swept, 256 combinations in all, and the fit or failure of the second request is computed arithmetically. The page space fills in a handful of commands, so gaps left by freed packets and the first-fit choice between them can be set up directly. The packet numbers run out before the pages do, which exercises failure for lack of a number independently of failure for lack of space. free_units moves between 0, 1 and 2, so every page returned by a free or release shows at the ports.

// File: rtl/pa_pkg.sv
// Shared definitions for the packet page allocator.
// Assumes no build of the allocator uses more than MASK_W pages.
package pa_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ALLOC   = 3'd1,
        OP_RESET   = 3'd2,
        OP_ENQUEUE = 3'd3,
        OP_FREE    = 3'd4,
        OP_RELEASE = 3'd5
    } cmd_op_e;

    localparam int MASK_W = 64;

    // Mask with bits first .. first+count-1 set.
    function automatic logic [MASK_W-1:0] run_mask(input int first, input int count);
        logic [MASK_W-1:0] m;
        for (int i = 0; i < MASK_W; i++) begin
            m[i] = (i >= first) && (i < first + count);
        end
        return m;
    endfunction

endpackage

// File: rtl/pa_run_finder.sv
// Finds the lowest-addressed run of need_m1+1 free pages in the bitmap.
// Purely combinational. A 1 bit in free_map marks a free page.
// Assumes NUM_PAGES <= pa_pkg::MASK_W.
module pa_run_finder
    import pa_pkg::*;
#(
    parameter int NUM_PAGES = 32,
    localparam int PW = $clog2(NUM_PAGES)
) (
    input  logic [NUM_PAGES-1:0] free_map,
    input  logic [PW-1:0]        need_m1,
    output logic                 found,
    output logic [PW-1:0]        base
);

    logic [MASK_W-1:0] free_wide;
    assign free_wide = MASK_W'(free_map);

    // Scan from the top page down so the lowest fitting start wins.
    always_comb begin
        logic [MASK_W-1:0] want;
        found = 1'b0;
        base  = '0;
        for (int s = NUM_PAGES - 1; s >= 0; s--) begin
            want = run_mask(s, int'(need_m1) + 1);
            if ((s + int'(need_m1) < NUM_PAGES) && ((free_wide & want) == want)) begin
                found = 1'b1;
                base  = PW'(s);
            end
        end
    end

endmodule

// File: rtl/pa_first_set.sv
// Priority encoder that returns the index of the lowest set bit.
// Purely combinational. found is 0 when no bit is set.
module pa_first_set #(
    parameter int W = 32,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top bit down so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/pa_pkt_fifo.sv
// First-in first-out store of packet numbers with a synchronous clear.
// A push into a full store is dropped unless a pop happens in the same cycle.
// A pop from an empty store is ignored. head is meaningful only while empty is 0.
module pa_pkt_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 5,
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          empty,
    output logic [DW-1:0] head
);

    logic [DW-1:0]   mem [DEPTH];
    logic [PTRW-1:0] wr_ptr;
    logic [PTRW-1:0] rd_ptr;
    logic [CNTW-1:0] count;
    logic            do_pop;
    logic            do_push;

    assign empty   = (count == '0);
    assign head    = mem[rd_ptr];
    assign do_pop  = pop && !empty;
    assign do_push = push && ((count != CNTW'(DEPTH)) || do_pop);

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTRW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTRW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
        end
    end

    // Store the pushed entry.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

endmodule

// File: rtl/pa_busy_timer.sv
// Holds busy high for BUSY_CYC cycles, starting the cycle after start.
// Assumes start is only pulsed while busy is low.
module pa_busy_timer #(
    parameter int BUSY_CYC = 4,
    localparam int TW = $clog2(BUSY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    logic [TW-1:0] remain;

    assign busy = (remain != '0);

    // Load the window on start and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= TW'(BUSY_CYC);
        end else if (busy) begin
            remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/pkt_page_alloc.sv
// Page allocator for a packet buffer split into fixed pages.
// Decodes host commands, keeps the free-page bitmap and the table that maps
// each packet number to its run of pages, and runs the transmit and receive
// queues of packet numbers. Results of a command appear the cycle after it.
// Assumes NUM_PKTS and NUM_PAGES are powers of two, NUM_PAGES <= 64, and
// NUM_PAGES is a multiple of PAGES_PER_UNIT.
module pkt_page_alloc
    import pa_pkg::*;
#(
    parameter int NUM_PAGES      = 32,
    parameter int NUM_PKTS       = 32,
    parameter int PAGES_PER_UNIT = 8,
    parameter int BUSY_CYC       = 4,
    localparam int PW = $clog2(NUM_PAGES),
    localparam int NW = $clog2(NUM_PKTS),
    localparam int AW = (PW > NW) ? PW : NW,
    localparam int UW = $clog2(NUM_PAGES / PAGES_PER_UNIT + 1),
    localparam int CW = $clog2(NUM_PAGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_arg,
    input  logic          int_ack,
    input  logic          rx_push,
    input  logic [NW-1:0] rx_push_pkt,
    input  logic          tx_pop,
    output logic          busy,
    output logic          cmd_err,
    output logic          alloc_int,
    output logic          alloc_fail,
    output logic [NW-1:0] alloc_pkt,
    output logic [PW-1:0] alloc_base,
    output logic [UW-1:0] free_units,
    output logic          tx_empty,
    output logic [NW-1:0] tx_head,
    output logic          rx_empty,
    output logic [NW-1:0] rx_head
);

    cmd_op_e op;
    logic    accept;
    logic    do_alloc;
    logic    do_reset;
    logic    do_enq;
    logic    do_free;
    logic    do_release;
    logic    rel_pop;

    logic [NUM_PAGES-1:0] free_map;
    logic [NUM_PKTS-1:0]  pkt_used;
    logic [PW-1:0]        pkt_first [NUM_PKTS];
    logic [PW-1:0]        pkt_len_m1 [NUM_PKTS];

    logic          run_ok;
    logic [PW-1:0] run_base;
    logic          num_ok;
    logic [NW-1:0] num_idx;
    logic          alloc_ok;
    logic [PW-1:0] need_m1;

    logic [NW-1:0]        free_sel;
    logic                 free_hit;
    logic [MASK_W-1:0]    take_wide;
    logic [MASK_W-1:0]    give_wide;
    logic [NUM_PAGES-1:0] take_mask;
    logic [NUM_PAGES-1:0] give_mask;
    logic [CW-1:0]        free_pages;

    // Command decode: a command is taken only while not busy.
    assign op         = cmd_op_e'(cmd_op);
    assign accept     = cmd_valid && !busy;
    assign do_alloc   = accept && (op == OP_ALLOC);
    assign do_reset   = accept && (op == OP_RESET);
    assign do_enq     = accept && (op == OP_ENQUEUE);
    assign do_free    = accept && (op == OP_FREE);
    assign do_release = accept && (op == OP_RELEASE);
    assign rel_pop    = do_release && !rx_empty;
    assign need_m1    = cmd_arg[PW-1:0];

    pa_run_finder #(
        .NUM_PAGES(NUM_PAGES)
    ) u_run (
        .free_map(free_map),
        .need_m1 (need_m1),
        .found   (run_ok),
        .base    (run_base)
    );

    pa_first_set #(
        .W(NUM_PKTS)
    ) u_num (
        .vec  (~pkt_used),
        .found(num_ok),
        .idx  (num_idx)
    );

    assign alloc_ok = run_ok && num_ok;

    // Pick the packet whose pages go back: the free argument or the receive head.
    always_comb begin
        free_sel = do_free ? cmd_arg[NW-1:0] : rx_head;
        free_hit = (do_free || rel_pop) && pkt_used[free_sel];
    end

    // Page masks for the run being taken and the run being returned.
    always_comb begin
        take_wide = run_mask(int'(run_base), int'(need_m1) + 1);
        give_wide = run_mask(int'(pkt_first[free_sel]), int'(pkt_len_m1[free_sel]) + 1);
        take_mask = take_wide[NUM_PAGES-1:0];
        give_mask = give_wide[NUM_PAGES-1:0];
    end

    // Bitmap, packet-number ownership, allocation result and interrupt bit.
    always_ff @(posedge clk) begin
        if (!rst_n || do_reset) begin
            free_map   <= '1;
            pkt_used   <= '0;
            alloc_int  <= 1'b0;
            alloc_fail <= 1'b0;
            alloc_pkt  <= '0;
            alloc_base <= '0;
        end else begin
            if (do_alloc) begin
                if (alloc_ok) begin
                    free_map          <= free_map & ~take_mask;
                    pkt_used[num_idx] <= 1'b1;
                    alloc_pkt         <= num_idx;
                    alloc_base        <= run_base;
                    alloc_fail        <= 1'b0;
                end else begin
                    alloc_fail <= 1'b1;
                end
            end else if (free_hit) begin
                free_map           <= free_map | give_mask;
                pkt_used[free_sel] <= 1'b0;
            end
            if (do_alloc && alloc_ok) begin
                alloc_int <= 1'b1;
            end else if (int_ack) begin
                alloc_int <= 1'b0;
            end
        end
    end

    // Record the run owned by a newly granted packet number.
    always_ff @(posedge clk) begin
        if (do_alloc && alloc_ok) begin
            pkt_first[num_idx]  <= run_base;
            pkt_len_m1[num_idx] <= need_m1;
        end
    end

    // Sticky error for commands that arrive during the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n || do_reset) begin
            cmd_err <= 1'b0;
        end else if (cmd_valid && busy) begin
            cmd_err <= 1'b1;
        end
    end

    pa_busy_timer #(
        .BUSY_CYC(BUSY_CYC)
    ) u_busy (
        .clk  (clk),
        .rst_n(rst_n),
        .start(do_free || do_release || do_reset),
        .busy (busy)
    );

    pa_pkt_fifo #(
        .DEPTH(NUM_PKTS),
        .DW   (NW)
    ) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (do_reset),
        .push     (do_enq),
        .push_data(cmd_arg[NW-1:0]),
        .pop      (tx_pop),
        .empty    (tx_empty),
        .head     (tx_head)
    );

    pa_pkt_fifo #(
        .DEPTH(NUM_PKTS),
        .DW   (NW)
    ) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (do_reset),
        .push     (rx_push),
        .push_data(rx_push_pkt),
        .pop      (rel_pop),
        .empty    (rx_empty),
        .head     (rx_head)
    );

    // Count free pages for the memory report.
    always_comb begin
        free_pages = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            free_pages = free_pages + CW'(free_map[i]);
        end
    end

    assign free_units = UW'(free_pages / CW'(PAGES_PER_UNIT));

endmodule

// File: rtl/pa_checker.sv
// Temporal checks on the allocator ports, bound into every instance.
// Assumes the command codes of pa_pkg and a busy window of BUSY_CYC cycles.
module pa_checker
    import pa_pkg::*;
#(
    parameter int BUSY_CYC  = 4,
    parameter int MAX_UNITS = 4,
    parameter int UW        = 3,
    localparam int LW = $clog2(BUSY_CYC + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic          busy,
    input logic          cmd_err,
    input logic          alloc_int,
    input logic          alloc_fail,
    input logic [UW-1:0] free_units
);

    logic [LW-1:0] busy_run;
    logic          took_long;
    logic          took_short;
    logic          took_reset;

    assign took_long  = cmd_valid && !busy &&
                        ((cmd_op == OP_FREE) || (cmd_op == OP_RELEASE) || (cmd_op == OP_RESET));
    assign took_short = cmd_valid && !busy &&
                        ((cmd_op == OP_ALLOC) || (cmd_op == OP_ENQUEUE));
    assign took_reset = cmd_valid && !busy && (cmd_op == OP_RESET);

    // Count the busy cycles seen so far in the current window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 1'b1;
        end else begin
            busy_run <= '0;
        end
    end

    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        took_long |=> busy);

    p_no_busy_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
        took_short |=> !busy);

    p_busy_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < LW'(BUSY_CYC)));

    p_busy_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == LW'(BUSY_CYC)));

    p_err_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> cmd_err);

    p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_err && !took_reset) |=> cmd_err);

    p_int_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alloc_int) |-> $past(cmd_valid && !busy && (cmd_op == OP_ALLOC)));

    p_int_not_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alloc_int) |-> !alloc_fail);

    p_units_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        free_units <= UW'(MAX_UNITS));

    p_reset_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        took_reset |=> ((free_units == UW'(MAX_UNITS)) && !alloc_int && !alloc_fail && !cmd_err));

endmodule

bind pkt_page_alloc pa_checker #(
    .BUSY_CYC (BUSY_CYC),
    .MAX_UNITS(NUM_PAGES / PAGES_PER_UNIT),
    .UW       (UW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .cmd_err   (cmd_err),
    .alloc_int (alloc_int),
    .alloc_fail(alloc_fail),
    .free_units(free_units)
);

// File: tb/sim_pkt_page_alloc.sv
// Self-checking bench for the page allocator, built with 16 pages and 8 packet numbers.
module sim_pkt_page_alloc;

    localparam int NP   = 16;
    localparam int NK   = 8;
    localparam int PPU  = 8;
    localparam int BCYC = 4;
    localparam int PW   = $clog2(NP);
    localparam int NW   = $clog2(NK);
    localparam int AW   = (PW > NW) ? PW : NW;
    localparam int UW   = $clog2(NP / PPU + 1);

    localparam logic [2:0] C_ALLOC = 3'd1;
    localparam logic [2:0] C_RESET = 3'd2;
    localparam logic [2:0] C_ENQ   = 3'd3;
    localparam logic [2:0] C_FREE  = 3'd4;
    localparam logic [2:0] C_REL   = 3'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_arg = '0;
    logic          int_ack = 1'b0;
    logic          rx_push = 1'b0;
    logic [NW-1:0] rx_push_pkt = '0;
    logic          tx_pop = 1'b0;
    logic          busy;
    logic          cmd_err;
    logic          alloc_int;
    logic          alloc_fail;
    logic [NW-1:0] alloc_pkt;
    logic [PW-1:0] alloc_base;
    logic [UW-1:0] free_units;
    logic          tx_empty;
    logic [NW-1:0] tx_head;
    logic          rx_empty;
    logic [NW-1:0] rx_head;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pkt_page_alloc #(
        .NUM_PAGES(NP), .NUM_PKTS(NK), .PAGES_PER_UNIT(PPU), .BUSY_CYC(BCYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .int_ack(int_ack), .rx_push(rx_push),
        .rx_push_pkt(rx_push_pkt), .tx_pop(tx_pop), .busy(busy),
        .cmd_err(cmd_err), .alloc_int(alloc_int), .alloc_fail(alloc_fail),
        .alloc_pkt(alloc_pkt), .alloc_base(alloc_base), .free_units(free_units),
        .tx_empty(tx_empty), .tx_head(tx_head), .rx_empty(rx_empty), .rx_head(rx_head)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input int arg);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_arg   = AW'(arg);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic ack_int();
        @(negedge clk);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic reset_cmd();
        cmd(C_RESET, 0);
        wait_idle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: state after reset
        chk("R1", "busy", busy, 0);
        chk("R1", "cmd_err", cmd_err, 0);
        chk("R1", "alloc_int", alloc_int, 0);
        chk("R1", "alloc_fail", alloc_fail, 0);
        chk("R1", "free_units", free_units, NP / PPU);
        chk("R1", "tx_empty", tx_empty, 1);
        chk("R1", "rx_empty", rx_empty, 1);

        // R2 R3 R5 R6: sweep over every pair of request sizes
        for (int a = 0; a < NP; a++) begin
            for (int b = 0; b < NP; b++) begin
                reset_cmd();
                cmd(C_ALLOC, a);
                if (b == 0) begin
                    chk("R2", "first base", alloc_base, 0);
                    chk("R6", "units after one", free_units, (NP - (a + 1)) / PPU);
                end
                ack_int();
                cmd(C_ALLOC, b);
                if ((a + 1) + (b + 1) <= NP) begin
                    chk("R3", "second base", alloc_base, a + 1);
                    chk("R3", "second pkt", alloc_pkt, 1);
                    chk("R6", "units after two", free_units, (NP - (a + b + 2)) / PPU);
                end else begin
                    chk("R5", "fail flag", alloc_fail, 1);
                    chk("R5", "no int on fail", alloc_int, 0);
                    chk("R5", "units unchanged", free_units, (NP - (a + 1)) / PPU);
                end
            end
        end

        // R4: interrupt clear, and set winning over a simultaneous clear
        reset_cmd();
        cmd(C_ALLOC, 0);
        chk("R4", "int set", alloc_int, 1);
        ack_int();
        chk("R4", "int cleared", alloc_int, 0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = C_ALLOC; cmd_arg = '0; int_ack = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; int_ack = 1'b0;
        chk("R4", "set wins over ack", alloc_int, 1);

        // R3 R5: packet numbers run out before pages do
        reset_cmd();
        for (int k = 0; k < NK; k++) begin
            cmd(C_ALLOC, 0);
            chk("R3", "pkt in order", alloc_pkt, k);
            chk("R3", "base in order", alloc_base, k);
        end
        cmd(C_ALLOC, 0);
        chk("R5", "fail no number", alloc_fail, 1);
        chk("R6", "units with 8 used", free_units, (NP - NK) / PPU);

        // R8 R10: free, busy window, reuse of the lowest number and run
        cmd(C_FREE, 3);
        for (int k = 0; k < BCYC; k++) begin
            chk("R10", "busy high", busy, 1);
            @(negedge clk);
        end
        chk("R10", "busy drops", busy, 0);
        cmd(C_ALLOC, 0);
        chk("R8", "reused pkt", alloc_pkt, 3);
        chk("R8", "reused base", alloc_base, 3);
        chk("R5", "fail cleared", alloc_fail, 0);

        // R3: first-fit into a hole left by a freed packet
        reset_cmd();
        for (int k = 0; k < 3; k++) begin
            cmd(C_ALLOC, 3);
            chk("R3", "quad base", alloc_base, 4 * k);
        end
        cmd(C_FREE, 1);
        wait_idle();
        cmd(C_ALLOC, 4);
        chk("R3", "five pages do not fit", alloc_fail, 1);
        cmd(C_ALLOC, 1);
        chk("R3", "hole pkt", alloc_pkt, 1);
        chk("R3", "hole base", alloc_base, 4);
        cmd(C_ALLOC, 1);
        chk("R3", "rest of hole pkt", alloc_pkt, 3);
        chk("R3", "rest of hole base", alloc_base, 6);
        cmd(C_ALLOC, 3);
        chk("R3", "top run base", alloc_base, 12);
        chk("R6", "memory full", free_units, 0);
        cmd(C_ALLOC, 0);
        chk("R5", "full fails", alloc_fail, 1);

        // R8: freeing an unused number returns nothing
        reset_cmd();
        cmd(C_ALLOC, 7);
        cmd(C_FREE, 5);
        wait_idle();
        chk("R8", "units after bogus free", free_units, 1);
        cmd(C_ALLOC, 7);
        chk("R8", "second half base", alloc_base, 8);
        cmd(C_ALLOC, 0);
        chk("R8", "nothing was freed", alloc_fail, 1);

        // R7 R10: transmit queue order, enqueue never busy
        reset_cmd();
        cmd(C_ENQ, 5);
        chk("R10", "enqueue not busy", busy, 0);
        cmd(C_ENQ, 2);
        cmd(C_ENQ, 7);
        chk("R7", "tx not empty", tx_empty, 0);
        chk("R7", "tx head first", tx_head, 5);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            tx_pop = 1'b1;
            @(negedge clk);
            tx_pop = 1'b0;
            if (k == 0) chk("R7", "tx head second", tx_head, 2);
            if (k == 1) chk("R7", "tx head third", tx_head, 7);
            if (k == 2) chk("R7", "tx drained", tx_empty, 1);
        end

        // R9: receive queue and release
        reset_cmd();
        cmd(C_ALLOC, 7);
        cmd(C_ALLOC, 3);
        chk("R6", "12 pages used", free_units, 0);
        @(negedge clk);
        rx_push = 1'b1; rx_push_pkt = 0;
        @(negedge clk);
        rx_push_pkt = 1;
        @(negedge clk);
        rx_push = 1'b0;
        chk("R9", "rx not empty", rx_empty, 0);
        chk("R9", "rx head", rx_head, 0);
        cmd(C_REL, 0);
        chk("R10", "release busy", busy, 1);
        wait_idle();
        chk("R9", "rx head next", rx_head, 1);
        chk("R9", "units after release", free_units, 1);
        cmd(C_REL, 0);
        wait_idle();
        chk("R9", "rx empty", rx_empty, 1);
        chk("R9", "units all back", free_units, 2);
        cmd(C_REL, 0);
        wait_idle();
        chk("R9", "empty release harmless", free_units, 2);

        // R11 R12: command during busy, sticky error, reset command
        reset_cmd();
        ack_int();
        cmd(C_ALLOC, 7);
        ack_int();
        cmd(C_FREE, 0);
        cmd(C_ALLOC, 0);
        chk("R11", "err set", cmd_err, 1);
        chk("R11", "ignored alloc no int", alloc_int, 0);
        wait_idle();
        chk("R11", "ignored alloc no pages", free_units, 2);
        cmd(C_ENQ, 4);
        chk("R11", "err sticky", cmd_err, 1);
        chk("R7", "enqueue taken", tx_empty, 0);
        cmd(C_ALLOC, 7);
        @(negedge clk);
        rx_push = 1'b1; rx_push_pkt = 2;
        @(negedge clk);
        rx_push = 1'b0;
        cmd(C_RESET, 0);
        chk("R12", "err cleared", cmd_err, 0);
        chk("R12", "int cleared", alloc_int, 0);
        chk("R12", "tx emptied", tx_empty, 1);
        chk("R12", "rx emptied", rx_empty, 1);
        chk("R12", "pages free", free_units, 2);
        wait_idle();
        cmd(C_ALLOC, 0);
        chk("R12", "numbers reset", alloc_pkt, 0);
        chk("R12", "pages reset", alloc_base, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule